// File: doc/BRIEF.md
# Interrupt Source Pending/Queued Coalescing Bank

This block holds the delivery state of a bank of interrupt sources. Each source has two state bits. P says a notification has gone to the downstream event queue and is waiting for end-of-interrupt. Q says another trigger arrived while P was set. A hardware trigger on a source forwards a notification only when the source is idle. Repeated triggers fold into the Q bit, so a source never sits in the queue more than once. An end-of-interrupt clears P. If Q was set, the end-of-interrupt sends the source on again.

Software reaches each source through its own 4 KiB management page. The source number comes from the address bits above the page offset. A load at one of a few fixed offsets is a single read-modify-write: it returns the state as it stood before the access and applies an action in the same cycle. The actions are end-of-interrupt, a plain read, and forcing the state to one of the four codes. A store at one further offset also performs end-of-interrupt. The `notify` output carries one pulse bit per source for the event queue to collect.

Top module: `irq_pq_bank`

## Requirements
- R1: After reset every source holds PQ=00, `notify` is all zero and `rsp_valid` is low.
- R2: A trigger on a source in state 00 moves it to 10 and raises that source's `notify` bit for one cycle, in the cycle after the trigger is sampled.
- R3: A trigger on a source in state 10 moves it to 11, and a trigger in state 11 leaves it at 11. Neither raises `notify`.
- R4: A trigger on a source in state 01 leaves it at 01 without a notification, so 01 acts as a mask.
- R5: End-of-interrupt is a load at offset 0x000 or a store at offset 0x400. It takes 10 to 00 without a notification, takes 11 to 10 with a notification, and leaves 00 and 01 unchanged.
- R6: A load at offset 0x800 returns the state and does not change it.
- R7: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 force PQ to 00, 01, 10 and 11 in that order, without a notification.
- R8: Every load raises `rsp_valid` one cycle later, and `rsp_data` carries the pre-access state with P in bit 1 and Q in bit 0. All other bits are zero. Stores produce no response.
- R9: When a trigger and a management access hit the same source in one cycle, the access is applied first and the trigger then acts on its result. The load still returns the state from before both.
- R10: A load at any other offset returns zero and changes nothing. A store at any offset other than 0x400 changes nothing.
- R11: The source is selected by `mmio_addr` bits above bit 11. An access or trigger on one source leaves every other source's state and `notify` bit untouched.
- R12: A source whose P bit is set raises no notification unless a management access touches it in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mmio_valid | input | 1 | Management access present this cycle |
| mmio_write | input | 1 | 1 = store, 0 = load |
| mmio_addr | input | SRC_W+12 | Source number in the upper bits, page offset in bits 11:0 |
| trig_valid | input | 1 | Hardware trigger present this cycle |
| trig_src | input | SRC_W | Source number of the trigger |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DATA_W | Pre-access state of the loaded source |
| notify | output | NUM_SRC | Per-source notification pulse to the event queue |

## Verification
The hardest case to reach from the ports is a management access and a trigger landing on the same source in the same cycle, from each of the four starting states. In that case the ordering rule decides both the new state and whether a notification leaves. The bench steers sources into 00 and 11 with the forcing offsets. It then issues end-of-interrupt or forcing loads together with a trigger on the same source. The random phase draws trigger and access sources from a small set so that such collisions keep recurring, and read-back loads expose the merged result.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;
  localparam int PAGE_BITS = 12;

  // bit 1 = P (forwarded, awaiting end-of-interrupt), bit 0 = Q (re-armed)
  typedef logic [1:0] pq_t;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_EOI   = 3'd1,
    OP_GET   = 3'd2,
    OP_SET00 = 3'd3,
    OP_SET01 = 3'd4,
    OP_SET10 = 3'd5,
    OP_SET11 = 3'd6
  } pq_op_e;

  function automatic pq_op_e pq_decode(input logic is_store, input logic [PAGE_BITS-1:0] ofs);
    pq_op_e op;
    op = OP_NONE;
    if (is_store) begin
      if (ofs == 12'h400) op = OP_EOI;
    end else begin
      case (ofs)
        12'h000: op = OP_EOI;
        12'h800: op = OP_GET;
        12'hC00: op = OP_SET00;
        12'hD00: op = OP_SET01;
        12'hE00: op = OP_SET10;
        12'hF00: op = OP_SET11;
        default: op = OP_NONE;
      endcase
    end
    return op;
  endfunction

  // returns {fire, next}
  function automatic logic [2:0] pq_on_trigger(input pq_t s);
    case (s)
      2'b00:   return {1'b1, 2'b10};
      2'b01:   return {1'b0, 2'b01};
      default: return {1'b0, 2'b11};
    endcase
  endfunction

  // returns {fire, next}
  function automatic logic [2:0] pq_on_eoi(input pq_t s);
    case (s)
      2'b10:   return {1'b0, 2'b00};
      2'b11:   return {1'b1, 2'b10};
      default: return {1'b0, s};
    endcase
  endfunction

  function automatic pq_t pq_forced(input pq_op_e op);
    case (op)
      OP_SET01: return 2'b01;
      OP_SET10: return 2'b10;
      OP_SET11: return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/irq_pq_decode.sv
module irq_pq_decode
  import irq_pq_pkg::*;
#(
  parameter int SRC_W = 3
) (
  input  logic                       valid_i,
  input  logic                       write_i,
  input  logic [SRC_W+PAGE_BITS-1:0] addr_i,
  output pq_op_e                     op_o,
  output logic [SRC_W-1:0]           idx_o,
  output logic                       load_o
);
  always_comb begin
    idx_o  = addr_i[SRC_W+PAGE_BITS-1:PAGE_BITS];
    load_o = valid_i && !write_i;
    op_o   = valid_i ? pq_decode(write_i, addr_i[PAGE_BITS-1:0]) : OP_NONE;
  end
endmodule

// File: rtl/irq_pq_cell.sv
module irq_pq_cell
  import irq_pq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  pq_op_e op_i,
  input  logic   trig_i,
  output pq_t    state_o,
  output logic   fire_o
);
  pq_t  st_q, after_mmio, after_trig;
  logic mmio_fire, trig_fire, fire_q;

  // management access first, trigger applied on its result
  always_comb begin
    after_mmio = st_q;
    mmio_fire  = 1'b0;
    case (op_i)
      OP_EOI: {mmio_fire, after_mmio} = pq_on_eoi(st_q);
      OP_SET00, OP_SET01, OP_SET10, OP_SET11: after_mmio = pq_forced(op_i);
      default: ;
    endcase
    if (trig_i) {trig_fire, after_trig} = pq_on_trigger(after_mmio);
    else        {trig_fire, after_trig} = {1'b0, after_mmio};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= 2'b00;
      fire_q <= 1'b0;
    end else begin
      st_q   <= after_trig;
      fire_q <= mmio_fire | trig_fire;
    end
  end

  assign state_o = st_q;
  assign fire_o  = fire_q;
endmodule

// File: rtl/irq_pq_bank.sv
module irq_pq_bank
  import irq_pq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 64,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mmio_valid,
  input  logic                       mmio_write,
  input  logic [SRC_W+PAGE_BITS-1:0] mmio_addr,
  input  logic                       trig_valid,
  input  logic [SRC_W-1:0]           trig_src,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_data,
  output logic [NUM_SRC-1:0]         notify
);
  localparam int PAD_W = DATA_W - 2;

  pq_op_e           dec_op;
  logic [SRC_W-1:0] dec_idx;
  logic             dec_load;
  pq_t              cell_state [NUM_SRC];

  // named events for the checker
  logic [2*NUM_SRC-1:0] ev_state;
  logic [NUM_SRC-1:0]   ev_mmio_hit;
  logic [NUM_SRC-1:0]   ev_get_hit;
  logic [NUM_SRC-1:0]   ev_trig_hit;

  irq_pq_decode #(.SRC_W(SRC_W)) u_dec (
    .valid_i (mmio_valid),
    .write_i (mmio_write),
    .addr_i  (mmio_addr),
    .op_o    (dec_op),
    .idx_o   (dec_idx),
    .load_o  (dec_load)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    pq_op_e cell_op;
    assign cell_op        = (dec_idx == SRC_W'(i)) ? dec_op : OP_NONE;
    assign ev_mmio_hit[i] = (cell_op != OP_NONE);
    assign ev_get_hit[i]  = (cell_op == OP_GET);
    assign ev_trig_hit[i] = trig_valid && (trig_src == SRC_W'(i));
    assign ev_state[2*i+1:2*i] = cell_state[i];

    irq_pq_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (cell_op),
      .trig_i  (ev_trig_hit[i]),
      .state_o (cell_state[i]),
      .fire_o  (notify[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= dec_load;
      if (dec_load)
        rsp_data <= (dec_op != OP_NONE) ? {{PAD_W{1'b0}}, cell_state[dec_idx]} : '0;
    end
  end
endmodule

module irq_pq_bank_chk #(
  parameter int NUM_SRC = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mmio_valid,
  input logic                 mmio_write,
  input logic                 rsp_valid,
  input logic [NUM_SRC-1:0]   notify,
  input logic [2*NUM_SRC-1:0] ev_state,
  input logic [NUM_SRC-1:0]   ev_mmio_hit,
  input logic [NUM_SRC-1:0]   ev_get_hit,
  input logic [NUM_SRC-1:0]   ev_trig_hit
);
  p_rsp_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_valid && !mmio_write) |=> rsp_valid);
  p_rsp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mmio_valid && !mmio_write) |=> !rsp_valid);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    p_notify_leaves_p_r2: assert property (@(posedge clk) disable iff (!rst_n)
      notify[i] |-> ev_state[2*i+1]);
    p_no_refire_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_state[2*i+1] && !ev_mmio_hit[i]) |=> !notify[i]);
    p_masked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_state[2*i+1:2*i] == 2'b01 && !ev_mmio_hit[i]) |=> (ev_state[2*i+1:2*i] == 2'b01) && !notify[i]);
    p_get_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_get_hit[i] && !ev_trig_hit[i]) |=> $stable(ev_state[2*i+1:2*i]) && !notify[i]);
  end
endmodule

bind irq_pq_bank irq_pq_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mmio_valid  (mmio_valid),
  .mmio_write  (mmio_write),
  .rsp_valid   (rsp_valid),
  .notify      (notify),
  .ev_state    (ev_state),
  .ev_mmio_hit (ev_mmio_hit),
  .ev_get_hit  (ev_get_hit),
  .ev_trig_hit (ev_trig_hit)
);

// File: tb/tb_irq_pq_bank.sv
module tb_irq_pq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int SW = 3;
  localparam int AW = SW + 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mmio_valid = 1'b0, mmio_write = 1'b0;
  logic [AW-1:0] mmio_addr = '0;
  logic          trig_valid = 1'b0;
  logic [SW-1:0] trig_src = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic [NS-1:0] notify;

  int checks = 0;
  int errors = 0;
  logic [1:0] m [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pq_bank dut (
    .clk(clk), .rst_n(rst_n), .mmio_valid(mmio_valid), .mmio_write(mmio_write),
    .mmio_addr(mmio_addr), .trig_valid(trig_valid), .trig_src(trig_src),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .notify(notify)
  );

  function automatic logic [AW-1:0] adr(input int src, input logic [11:0] ofs);
    return {src[SW-1:0], ofs};
  endfunction

  // trigger model: {fire, next}
  function automatic logic [2:0] m_trig(input logic [1:0] s);
    if (!s[1] && s[0]) return {1'b0, s};
    if (!s[1])         return {1'b1, 2'b10};
    return {1'b0, 2'b11};
  endfunction

  function automatic logic [2:0] m_eoi(input logic [1:0] s);
    if (!s[1]) return {1'b0, s};
    if (s[0])  return {1'b1, 2'b10};
    return {1'b0, 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample at the next negedge
  task automatic step(input logic mv, input logic mw, input logic [AW-1:0] a,
                      input logic tv, input int ts, input string tag);
    logic [NS-1:0] exp_n;
    logic [63:0]   exp_d;
    logic [1:0]    nxt [NS];
    logic [2:0]    r;
    int            sa;
    logic [11:0]   o;
    sa = int'(a[AW-1:12]);
    o  = a[11:0];
    exp_n = '0;
    exp_d = '0;
    for (int s = 0; s < NS; s++) begin
      nxt[s] = m[s];
      if (mv && sa == s) begin
        if (!mw) begin
          if (o == 12'h000 || o == 12'h800 || o[11:10] == 2'b11 && o[7:0] == 8'h00)
            exp_d = {62'b0, m[s]};
        end
        if ((!mw && o == 12'h000) || (mw && o == 12'h400)) begin
          r = m_eoi(m[s]); exp_n[s] = r[2]; nxt[s] = r[1:0];
        end else if (!mw && o[11:10] == 2'b11 && o[7:0] == 8'h00) begin
          nxt[s] = o[9:8];
        end
      end
      if (tv && ts == s) begin
        r = m_trig(nxt[s]);
        exp_n[s] = exp_n[s] | r[2];
        nxt[s] = r[1:0];
      end
    end
    mmio_valid = mv; mmio_write = mw; mmio_addr = a;
    trig_valid = tv; trig_src = ts[SW-1:0];
    @(posedge clk);
    @(negedge clk);
    mmio_valid = 1'b0; trig_valid = 1'b0;
    chk({tag, " notify"}, 64'(notify), 64'(exp_n));
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'(mv && !mw));
    if (mv && !mw) chk({tag, " rsp_data"}, rsp_data, exp_d);
    for (int s = 0; s < NS; s++) m[s] = nxt[s];
  endtask

  task automatic get(input int s, input string tag);
    step(1'b1, 1'b0, adr(s, 12'h800), 1'b0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] ofs_tab [8];
    void'($urandom(32'h5EED_1234));
    ofs_tab = '{12'h000, 12'h400, 12'h800, 12'hC00, 12'hD00, 12'hE00, 12'hF00, 12'h123};
    for (int s = 0; s < NS; s++) m[s] = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 notify in reset", 64'(notify), 64'h0);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    get(0, "R1 state after reset");
    // R2, R3
    step(1'b0, 1'b0, '0, 1'b1, 3, "R2 first trigger");
    step(1'b0, 1'b0, '0, 1'b1, 3, "R3 trigger from 10");
    step(1'b0, 1'b0, '0, 1'b1, 3, "R3 trigger from 11");
    get(3, "R8 read 11");
    // R5
    step(1'b1, 1'b0, adr(3, 12'h000), 1'b0, 0, "R5 load eoi from 11");
    step(1'b1, 1'b1, adr(3, 12'h400), 1'b0, 0, "R5 store eoi from 10");
    get(3, "R5 read back");
    step(1'b1, 1'b0, adr(3, 12'h000), 1'b0, 0, "R5 eoi from 00");
    // R7, R4
    step(1'b1, 1'b0, adr(5, 12'hD00), 1'b0, 0, "R7 force 01");
    step(1'b0, 1'b0, '0, 1'b1, 5, "R4 masked trigger");
    get(5, "R4 still masked");
    step(1'b1, 1'b0, adr(5, 12'h000), 1'b0, 0, "R5 eoi from 01");
    step(1'b1, 1'b0, adr(5, 12'hE00), 1'b0, 0, "R7 force 10");
    step(1'b1, 1'b0, adr(5, 12'hF00), 1'b0, 0, "R7 force 11");
    step(1'b1, 1'b0, adr(5, 12'hC00), 1'b0, 0, "R7 force 00");
    step(1'b1, 1'b0, adr(5, 12'hD00), 1'b0, 0, "R7 force 01 again");
    // R10, R6
    step(1'b1, 1'b0, adr(5, 12'h400), 1'b0, 0, "R10 load at store offset");
    step(1'b1, 1'b1, adr(5, 12'hC00), 1'b0, 0, "R10 store at force offset");
    step(1'b1, 1'b0, adr(5, 12'h7F8), 1'b0, 0, "R10 unlisted load");
    get(5, "R6 get unchanged");
    get(5, "R6 get twice");
    // R9
    step(1'b1, 1'b0, adr(6, 12'h000), 1'b1, 6, "R9 eoi+trigger from 00");
    step(1'b1, 1'b0, adr(6, 12'hF00), 1'b1, 6, "R9 force 11 + trigger");
    step(1'b1, 1'b0, adr(6, 12'h000), 1'b1, 6, "R9 eoi 11 + trigger");
    get(6, "R9 merged state");
    step(1'b1, 1'b0, adr(6, 12'hC00), 1'b1, 6, "R9 force 00 + trigger");
    // R11
    step(1'b1, 1'b0, adr(2, 12'hF00), 1'b1, 1, "R11 distinct sources");
    get(1, "R11 src1");
    get(2, "R11 src2");
    step(1'b1, 1'b0, adr(2, 12'h000), 1'b1, 7, "R11 eoi and trigger elsewhere");
    // R12 random mix over few sources to force collisions
    for (int k = 0; k < 600; k++) begin
      int as, ts;
      logic mv, mw, tv;
      as = $urandom_range(0, 3);
      ts = $urandom_range(0, 3);
      mv = ($urandom_range(0, 3) != 0);
      mw = ($urandom_range(0, 4) == 0);
      tv = ($urandom_range(0, 1) == 1);
      step(mv, mw, adr(as, ofs_tab[$urandom_range(0, 7)]), tv, ts, "R12 random");
    end
    for (int s = 0; s < NS; s++) get(s, "R12 final state");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule